// File: doc/BRIEF.md
# NAND Flash Host Port

This block sits between a processor's simple register bus and an asynchronous NAND flash device. Software loads command bytes, address bytes and write data into a small queue. The block then plays each queued entry onto the flash bus as one strobed cycle, with a strobe low time set in a configuration register. A single-word read takes two steps. Software first posts a read request, and the value written with it is ignored. It then waits for a read-ready flag and fetches the captured word from a holding register.

A page-control register starts a burst of back-to-back read or write cycles, one page long. During a read burst each captured word is handed to an external DMA port. During a write burst each word is taken from that port. A sticky flag register records three events: the flash leaving busy, a completed single read and a completed page burst. A mask register selects which of these drive the interrupt line. Chip enable stays low for as long as there is queued or burst work.

Register offsets on `reg_addr`:

| Offset | Name | Access | Contents |
|---|---|---|---|
| 0 | CFG | read/write | bit 9 page size (0 = 256, 1 = 512 bytes), bit 8 bus width (0 = 8-bit, 1 = 16-bit), bits 7:4 read strobe delay, bits 3:0 write strobe delay |
| 1 | STAT | read only | bit 0 queue full, bit 1 bus active (chip enable asserted) |
| 2 | FLAGS | read, write-one-to-clear | bit 0 flash became ready, bit 1 read ready, bit 2 page burst done |
| 3 | MASK | read/write | bits 2:0 interrupt enables, one per FLAGS bit |
| 4 | CMD | write | queue a command cycle |
| 5 | ADDR | write | queue an address cycle |
| 6 | WDATA | write | queue a data write cycle |
| 7 | RDREQ | write | queue a data read cycle (written value ignored) |
| 8 | RDDATA | read | word captured by the most recent single read |
| 9 | PAGE | write | 1 starts a page read burst, 2 starts a page write burst |

Top module: `nand_host_port`

## Requirements
- R1: After reset, nf_ce_n, nf_we_n and nf_re_n are high, nf_cle, nf_ale and irq are low, and MASK, FLAGS and STAT read as zero.
- R2: A CMD write produces one flash cycle with nf_cle high and nf_ale low. An ADDR write produces one cycle with nf_ale high and nf_cle low. Each such cycle pulses nf_we_n low and drives the written byte on nf_dout.
- R3: The queue holds 4 entries, and STAT bit 0 reads 1 while all 4 are occupied. A CMD, ADDR, WDATA or RDREQ write made while the queue is full is dropped and produces no flash cycle.
- R4: A write-type strobe (nf_we_n) stays low for CFG[3:0]+1 clocks. A read strobe (nf_re_n) stays low for CFG[7:4]+1 clocks. The two strobes are never low together.
- R5: An RDREQ write performs one nf_re_n cycle. The word sampled on nf_din then appears in RDDATA, and FLAGS bit 1 is set.
- R6: Writing FLAGS clears every bit written as 1 and leaves the bits written as 0 untouched. If a flag's set event falls in the same cycle as its clear, the flag stays set.
- R7: FLAGS bit 0 is set when nf_rb, after a two-stage synchronizer, changes from 0 (busy) to 1 (ready).
- R8: With CFG bit 8 = 0, data cycles drive only nf_dout[7:0], upper bits zero, and captured read words have their upper byte zeroed. With CFG bit 8 = 1, all 16 bits pass. Command and address cycles always drive zero on nf_dout[15:8].
- R9: Writing 1 to PAGE performs N read cycles, each captured word pulsing dma_rd_valid with dma_rd_data. Writing 2 performs N write cycles, each taking dma_wr_data and pulsing dma_wr_take. N is 256 or 512 by CFG bit 9, halved when CFG bit 8 = 1. FLAGS bit 2 is set when the last cycle ends.
- R10: nf_ce_n is low while any strobe is low, and stays low from the cycle after the first queued write until the queue is empty, the bus is idle and no burst is pending.
- R11: irq is high exactly when some FLAGS bit and the matching MASK bit are both 1.
- R12: A PAGE write while a burst is in progress has no effect, and PAGE values other than 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobe delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | 1 = write access, 0 = read |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (no read side effects) |
| irq | output | 1 | Masked OR of the sticky flags |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dout | output | 16 | Data driven toward the flash |
| nf_doe | output | 1 | Output enable for nf_dout |
| nf_din | input | 16 | Data returned by the flash |
| nf_rb | input | 1 | Flash ready/busy, 1 = ready |
| dma_rd_valid | output | 1 | One-cycle pulse per word captured during a read burst |
| dma_rd_data | output | 16 | Word captured during a read burst |
| dma_wr_data | input | 16 | Next word for a write burst |
| dma_wr_take | output | 1 | dma_wr_data is consumed in this cycle |

## Verification
Two events can land on one flag in the same clock: a host write-one-to-clear to FLAGS and a hardware set of that flag. The bench provokes this by raising nf_rb at a known falling edge and placing the clear of bit 0 on exactly the rising edge where the synchronized edge sets it, which is the third edge after the change. It judges the outcome by reading FLAGS bit 0 back as 1, and then shows that an isolated clear does remove it. A second overlap is a host push arriving in the same cycle as a pop or a full queue. It is covered by filling the queue behind a slow strobe and checking that exactly the first five data words, and not the sixth, reach the bus.

// File: rtl/nfh_pkg.sv
package nfh_pkg;

    localparam int NFH_DW    = 16;
    localparam int NFH_DLY_W = 4;
    localparam int NFH_AW    = 4;

    // register offsets
    localparam logic [NFH_AW-1:0] RA_CFG    = 4'd0;
    localparam logic [NFH_AW-1:0] RA_STAT   = 4'd1;
    localparam logic [NFH_AW-1:0] RA_FLAGS  = 4'd2;
    localparam logic [NFH_AW-1:0] RA_MASK   = 4'd3;
    localparam logic [NFH_AW-1:0] RA_CMD    = 4'd4;
    localparam logic [NFH_AW-1:0] RA_ADDR   = 4'd5;
    localparam logic [NFH_AW-1:0] RA_WDATA  = 4'd6;
    localparam logic [NFH_AW-1:0] RA_RDREQ  = 4'd7;
    localparam logic [NFH_AW-1:0] RA_RDDATA = 4'd8;
    localparam logic [NFH_AW-1:0] RA_PAGE   = 4'd9;

    localparam int FLAG_N = 3;

    typedef enum logic [1:0] {
        CYC_CMD  = 2'd0,
        CYC_ADDR = 2'd1,
        CYC_WDAT = 2'd2,
        CYC_RDAT = 2'd3
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        cyc_kind_e         kind;
        logic [NFH_DW-1:0] data;
    } wb_entry_t;

    // field order matches the configuration register, bit 9 down to bit 0
    typedef struct packed {
        logic                 page_big;
        logic                 wide;
        logic [NFH_DLY_W-1:0] rd_dly;
        logic [NFH_DLY_W-1:0] wr_dly;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/nfh_wbuf.sv
module nfh_wbuf
    import nfh_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  wb_entry_t                    push_entry,
    input  logic                         pop,
    output wb_entry_t                    head,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        wb_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } wb_t;

    wb_t q, d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        logic do_push, do_pop;
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = push_entry;
            d.wp        = bump(q.wp);
        end
        if (do_pop) begin
            d.rp = bump(q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign count = q.cnt;

endmodule

// File: rtl/nfh_engine.sv
module nfh_engine
    import nfh_pkg::*;
#(
    parameter int DW         = NFH_DW,
    parameter int PAGE_SMALL = 256,
    parameter int PAGE_BIG   = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic          fifo_empty,
    input  wb_entry_t     fifo_head,
    output logic          fifo_pop,
    input  logic          burst_start,
    input  logic          burst_rd,
    output logic          burst_busy,
    output logic          busy,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic          nf_we_n,
    output logic          nf_re_n,
    output logic [DW-1:0] nf_dout,
    output logic          nf_doe,
    input  logic [DW-1:0] nf_din,
    output logic          cap_valid,
    output logic [DW-1:0] cap_data,
    output logic          dma_rd_valid,
    output logic [DW-1:0] dma_rd_data,
    input  logic [DW-1:0] dma_wr_data,
    output logic          dma_wr_take,
    output logic          page_done
);
    localparam int HW    = DW / 2;
    localparam int LEN_W = $clog2(PAGE_BIG + 1);

    typedef struct packed {
        phase_e               phase;
        cyc_kind_e            kind;
        logic [DW-1:0]        data;
        logic [NFH_DLY_W-1:0] cnt;
        logic                 from_burst;
        logic                 burst_on;
        logic                 burst_rd;
        logic [LEN_W-1:0]     left;
        logic                 cap_v;
        logic [DW-1:0]        cap_d;
        logic                 dma_v;
        logic [DW-1:0]        dma_d;
        logic                 done;
    } eng_t;

    eng_t q, d;

    function automatic logic [DW-1:0] lane(input logic [DW-1:0] v, input logic full_w);
        return full_w ? v : {{(DW-HW){1'b0}}, v[HW-1:0]};
    endfunction

    logic [LEN_W-1:0] page_base, page_words;
    assign page_base  = cfg.page_big ? LEN_W'(PAGE_BIG) : LEN_W'(PAGE_SMALL);
    assign page_words = cfg.wide ? (page_base >> 1) : page_base;

    always_comb begin
        d           = q;
        d.cap_v     = 1'b0;
        d.dma_v     = 1'b0;
        d.done      = 1'b0;
        fifo_pop    = 1'b0;
        dma_wr_take = 1'b0;

        if (burst_start && !q.burst_on) begin
            d.burst_on = 1'b1;
            d.burst_rd = burst_rd;
            d.left     = page_words;
        end

        case (q.phase)
            PH_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop     = 1'b1;
                    d.kind       = fifo_head.kind;
                    d.from_burst = 1'b0;
                    d.phase      = PH_LOW;
                    if (fifo_head.kind == CYC_RDAT) begin
                        d.cnt  = cfg.rd_dly;
                        d.data = '0;
                    end else begin
                        d.cnt  = cfg.wr_dly;
                        d.data = lane(fifo_head.data,
                                      cfg.wide && (fifo_head.kind == CYC_WDAT));
                    end
                end else if (q.burst_on && (q.left != '0)) begin
                    d.from_burst = 1'b1;
                    d.phase      = PH_LOW;
                    d.left       = q.left - LEN_W'(1);
                    if (q.burst_rd) begin
                        d.kind = CYC_RDAT;
                        d.cnt  = cfg.rd_dly;
                        d.data = '0;
                    end else begin
                        d.kind      = CYC_WDAT;
                        d.cnt       = cfg.wr_dly;
                        d.data      = lane(dma_wr_data, cfg.wide);
                        dma_wr_take = 1'b1;
                    end
                end
            end
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.phase = PH_HIGH;
                    if (q.kind == CYC_RDAT) begin
                        if (q.from_burst) begin
                            d.dma_v = 1'b1;
                            d.dma_d = lane(nf_din, cfg.wide);
                        end else begin
                            d.cap_v = 1'b1;
                            d.cap_d = lane(nf_din, cfg.wide);
                        end
                    end
                end else begin
                    d.cnt = q.cnt - NFH_DLY_W'(1);
                end
            end
            PH_HIGH: begin
                d.phase = PH_IDLE;
                if (q.from_burst && (q.left == '0)) begin
                    d.burst_on   = 1'b0;
                    d.from_burst = 1'b0;
                    d.done       = 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic active;
    assign active  = (q.phase != PH_IDLE);
    assign nf_cle  = active && (q.kind == CYC_CMD);
    assign nf_ale  = active && (q.kind == CYC_ADDR);
    assign nf_we_n = !((q.phase == PH_LOW) && (q.kind != CYC_RDAT));
    assign nf_re_n = !((q.phase == PH_LOW) && (q.kind == CYC_RDAT));
    assign nf_doe  = active && (q.kind != CYC_RDAT);
    assign nf_dout = q.data;

    assign burst_busy   = q.burst_on;
    assign busy         = active || q.burst_on;
    assign cap_valid    = q.cap_v;
    assign cap_data     = q.cap_d;
    assign dma_rd_valid = q.dma_v;
    assign dma_rd_data  = q.dma_d;
    assign page_done    = q.done;

endmodule

// File: rtl/nand_host_port.sv
module nand_host_port
    import nfh_pkg::*;
#(
    parameter int DW         = NFH_DW,
    parameter int AW         = NFH_AW,
    parameter int WB_DEPTH   = 4,
    parameter int PAGE_SMALL = 256,
    parameter int PAGE_BIG   = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          nf_ce_n,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic          nf_we_n,
    output logic          nf_re_n,
    output logic [DW-1:0] nf_dout,
    output logic          nf_doe,
    input  logic [DW-1:0] nf_din,
    input  logic          nf_rb,
    output logic          dma_rd_valid,
    output logic [DW-1:0] dma_rd_data,
    input  logic [DW-1:0] dma_wr_data,
    output logic          dma_wr_take
);
    localparam int CW = $clog2(WB_DEPTH + 1);

    typedef struct packed {
        cfg_t              cfg;
        logic [FLAG_N-1:0] flags;
        logic [FLAG_N-1:0] mask;
        logic [DW-1:0]     rdbuf;
        logic [2:0]        rb_sync;
    } top_t;

    top_t q, d;

    logic      wb_full, wb_empty, wb_pop, push_try;
    logic [CW-1:0] wb_count;
    wb_entry_t push_entry, wb_head;
    logic      burst_start, burst_rd, burst_busy, eng_busy;
    logic      cap_valid, page_done;
    logic [DW-1:0] cap_data;
    logic [FLAG_N-1:0] flags_now;
    logic [NFH_DLY_W-1:0] cfg_wr_dly, cfg_rd_dly;

    logic host_wr;
    assign host_wr = reg_sel && reg_we;

    // queue entry decode
    always_comb begin
        push_try   = 1'b0;
        push_entry = '{kind: CYC_CMD, data: reg_wdata};
        if (host_wr) begin
            case (reg_addr)
                RA_CMD:   begin push_try = 1'b1; push_entry.kind = CYC_CMD;  end
                RA_ADDR:  begin push_try = 1'b1; push_entry.kind = CYC_ADDR; end
                RA_WDATA: begin push_try = 1'b1; push_entry.kind = CYC_WDAT; end
                RA_RDREQ: begin
                    push_try        = 1'b1;
                    push_entry.kind = CYC_RDAT;
                    push_entry.data = '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        logic [FLAG_N-1:0] clr, set;
        logic              rb_rise;
        d           = q;
        burst_start = 1'b0;
        burst_rd    = 1'b0;

        d.rb_sync = {q.rb_sync[1:0], nf_rb};
        rb_rise   = q.rb_sync[1] && !q.rb_sync[2];

        clr = '0;
        if (host_wr) begin
            case (reg_addr)
                RA_CFG:   d.cfg  = cfg_t'(reg_wdata[CFG_W-1:0]);
                RA_MASK:  d.mask = reg_wdata[FLAG_N-1:0];
                RA_FLAGS: clr    = reg_wdata[FLAG_N-1:0];
                RA_PAGE: begin
                    if (!burst_busy) begin
                        if (reg_wdata == DW'(1)) begin
                            burst_start = 1'b1;
                            burst_rd    = 1'b1;
                        end else if (reg_wdata == DW'(2)) begin
                            burst_start = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        set     = {page_done, cap_valid, rb_rise};
        d.flags = (q.flags & ~clr) | set;

        if (cap_valid) d.rdbuf = cap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.rb_sync <= '1;
        end else begin
            q <= d;
        end
    end

    nfh_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_try),
        .push_entry (push_entry),
        .pop        (wb_pop),
        .head       (wb_head),
        .full       (wb_full),
        .empty      (wb_empty),
        .count      (wb_count)
    );

    nfh_engine #(
        .DW         (DW),
        .PAGE_SMALL (PAGE_SMALL),
        .PAGE_BIG   (PAGE_BIG)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg          (q.cfg),
        .fifo_empty   (wb_empty),
        .fifo_head    (wb_head),
        .fifo_pop     (wb_pop),
        .burst_start  (burst_start),
        .burst_rd     (burst_rd),
        .burst_busy   (burst_busy),
        .busy         (eng_busy),
        .nf_cle       (nf_cle),
        .nf_ale       (nf_ale),
        .nf_we_n      (nf_we_n),
        .nf_re_n      (nf_re_n),
        .nf_dout      (nf_dout),
        .nf_doe       (nf_doe),
        .nf_din       (nf_din),
        .cap_valid    (cap_valid),
        .cap_data     (cap_data),
        .dma_rd_valid (dma_rd_valid),
        .dma_rd_data  (dma_rd_data),
        .dma_wr_data  (dma_wr_data),
        .dma_wr_take  (dma_wr_take),
        .page_done    (page_done)
    );

    assign nf_ce_n    = wb_empty && !eng_busy;
    assign irq        = |(q.flags & q.mask);
    assign flags_now  = q.flags;
    assign cfg_wr_dly = q.cfg.wr_dly;
    assign cfg_rd_dly = q.cfg.rd_dly;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CFG:    reg_rdata = DW'(q.cfg);
            RA_STAT:   reg_rdata = DW'({!nf_ce_n, wb_full});
            RA_FLAGS:  reg_rdata = DW'(q.flags);
            RA_MASK:   reg_rdata = DW'(q.mask);
            RA_RDDATA: reg_rdata = q.rdbuf;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nfh_chk.sv
module nfh_chk
    import nfh_pkg::*;
#(
    parameter int CW = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 nf_we_n,
    input logic                 nf_re_n,
    input logic                 nf_cle,
    input logic                 nf_ale,
    input logic                 nf_ce_n,
    input logic [NFH_DLY_W-1:0] cfg_wr_dly,
    input logic [NFH_DLY_W-1:0] cfg_rd_dly,
    input logic                 wb_full,
    input logic                 push_try,
    input logic [CW-1:0]        wb_count,
    input logic                 cap_valid,
    input logic [FLAG_N-1:0]    flags_now
);
    localparam int LW = NFH_DLY_W + 1;

    logic [LW-1:0] we_low, re_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low <= '0;
            re_low <= '0;
        end else begin
            we_low <= nf_we_n ? '0 : we_low + LW'(1);
            re_low <= nf_re_n ? '0 : re_low + LW'(1);
        end
    end

    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    // R4
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_we_n) |-> (we_low == LW'(cfg_wr_dly) + LW'(1)));

    // R4
    re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nf_re_n) |-> (re_low == LW'(cfg_rd_dly) + LW'(1)));

    // R10
    ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_full && push_try) |=> (wb_count <= $past(wb_count)));

    // R5
    rd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> flags_now[1]);

endmodule

bind nand_host_port nfh_chk #(.CW($clog2(WB_DEPTH + 1))) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nf_we_n    (nf_we_n),
    .nf_re_n    (nf_re_n),
    .nf_cle     (nf_cle),
    .nf_ale     (nf_ale),
    .nf_ce_n    (nf_ce_n),
    .cfg_wr_dly (cfg_wr_dly),
    .cfg_rd_dly (cfg_rd_dly),
    .wb_full    (wb_full),
    .push_try   (push_try),
    .wb_count   (wb_count),
    .cap_valid  (cap_valid),
    .flags_now  (flags_now)
);

// File: tb/nand_host_port_tb.sv
`timescale 1ns/1ps
module nand_host_port_tb;
    localparam logic [3:0] A_CFG = 4'd0, A_STAT = 4'd1, A_FLAGS = 4'd2, A_MASK = 4'd3,
                           A_CMD = 4'd4, A_ADDR = 4'd5, A_WDATA = 4'd6, A_RDREQ = 4'd7,
                           A_RDDATA = 4'd8, A_PAGE = 4'd9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_doe;
    logic [15:0] nf_dout;
    logic [15:0] nf_din;
    logic nf_rb = 1'b1;
    logic dma_rd_valid, dma_wr_take;
    logic [15:0] dma_rd_data, dma_wr_data;

    always #2 clk = ~clk;

    nand_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dout(nf_dout), .nf_doe(nf_doe),
        .nf_din(nf_din), .nf_rb(nf_rb), .dma_rd_valid(dma_rd_valid),
        .dma_rd_data(dma_rd_data), .dma_wr_data(dma_wr_data), .dma_wr_take(dma_wr_take)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // flash responder and bus monitor
    logic [15:0] flash_q = 16'hC3A5;
    assign nf_din = flash_q;
    int take_cnt = 0;
    assign dma_wr_data = 16'h5000 + take_cnt[15:0];
    always @(posedge clk) if (dma_wr_take) take_cnt <= take_cnt + 1;

    int log_n = 0;
    int log_kind [0:1023];
    int log_w    [0:1023];
    logic [15:0] log_d [0:1023];
    int wl = 0, rl = 0, wk = 0, ce_bad = 0;
    logic [15:0] wd;
    int rdv_cnt = 0, rdv_bad = 0;
    logic [15:0] rdv_base = '0;

    always @(negedge clk) begin
        if (dma_rd_valid) begin
            if (dma_rd_data != {8'h00, rdv_base[7:0] + rdv_cnt[7:0]}) rdv_bad++;
            rdv_cnt++;
        end
        if (!nf_we_n) begin
            wl++; wd = nf_dout; wk = nf_cle ? 0 : (nf_ale ? 1 : 2);
            if (nf_ce_n) ce_bad++;
        end else if (wl > 0) begin
            if (log_n < 1024) begin log_kind[log_n] = wk; log_w[log_n] = wl; log_d[log_n] = wd; end
            log_n++; wl = 0;
        end
        if (!nf_re_n) begin
            rl++;
            if (nf_ce_n) ce_bad++;
        end else if (rl > 0) begin
            if (log_n < 1024) begin log_kind[log_n] = 3; log_w[log_n] = rl; log_d[log_n] = 16'h0; end
            log_n++; rl = 0; flash_q = flash_q + 16'h0101;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_sel = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            reg_rd(A_STAT, s);
            if (!s[1]) return;
        end
    endtask

    task automatic wait_flag(input int b, output bit seen);
        logic [15:0] f;
        seen = 0;
        for (int i = 0; i < 4000; i++) begin
            reg_rd(A_FLAGS, f);
            if (f[b]) begin seen = 1; return; end
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk(nf_ce_n === 1'b1, "R1 ce_n", nf_ce_n, 1);
        chk(nf_we_n === 1'b1 && nf_re_n === 1'b1, "R1 strobes", {nf_we_n, nf_re_n}, 3);
        chk(nf_cle === 1'b0 && nf_ale === 1'b0, "R1 latches", {nf_cle, nf_ale}, 0);
        chk(irq === 1'b0, "R1/R11 irq", irq, 0);
        reg_rd(A_MASK, v);  chk(v == 0, "R1 mask", v, 0);
        reg_rd(A_FLAGS, v); chk(v == 0, "R1 flags", v, 0);
        reg_rd(A_STAT, v);  chk(v == 0, "R1 stat", v, 0);
    endtask

    task automatic t_cmd_addr();
        int b = log_n;
        reg_wr(A_CFG, 16'h0012);
        reg_wr(A_CMD, 16'h01F0);
        chk(nf_ce_n === 1'b0, "R10 ce after queue", nf_ce_n, 0);
        reg_wr(A_ADDR, 16'h0034);
        wait_idle();
        chk(log_n - b == 2, "R2 cycle count", log_n - b, 2);
        chk(log_kind[b] == 0 && log_d[b] == 16'h00F0, "R2/R8 cmd cycle", {log_kind[b], log_d[b]}, 16'h00F0);
        chk(log_kind[b+1] == 1 && log_d[b+1] == 16'h0034, "R2 addr cycle", {log_kind[b+1], log_d[b+1]}, 32'h10034);
        chk(log_w[b] == 3 && log_w[b+1] == 3, "R4 write width", log_w[b], 3);
        chk(ce_bad == 0, "R10 ce during strobes", ce_bad, 0);
        chk(nf_ce_n === 1'b1, "R10 ce released", nf_ce_n, 1);
    endtask

    task automatic t_full();
        int b = log_n;
        logic [15:0] s;
        reg_wr(A_CFG, 16'h000F);
        for (int i = 0; i < 6; i++) reg_wr(A_WDATA, 16'hAB11 + 16'(i));
        reg_rd(A_STAT, s);
        chk(s[0] == 1'b1, "R3 full flag", s, 1);
        wait_idle();
        chk(log_n - b == 5, "R3 sixth write dropped", log_n - b, 5);
        for (int i = 0; i < 5; i++)
            chk(log_d[b+i] == 16'h0011 + 16'(i) && log_w[b+i] == 16, "R3/R8/R4 queued data",
                log_d[b+i], 16'h0011 + 16'(i));
        reg_rd(A_STAT, s);
        chk(s[0] == 1'b0, "R3 full clears", s, 0);
    endtask

    task automatic t_read(input bit wide);
        logic [15:0] v, exp;
        bit seen;
        int b = log_n;
        reg_wr(A_CFG, wide ? 16'h0130 : 16'h0030);
        exp = wide ? flash_q : {8'h00, flash_q[7:0]};
        reg_wr(A_RDREQ, 16'hDEAD);
        wait_flag(1, seen);
        chk(seen, "R5 read ready", seen, 1);
        reg_rd(A_RDDATA, v);
        chk(v == exp, wide ? "R5/R8 wide read" : "R5/R8 narrow read", v, exp);
        chk(log_kind[b] == 3 && log_w[b] == 4, "R4 read width", log_w[b], 4);
        reg_wr(A_FLAGS, 16'h0000);
        reg_rd(A_FLAGS, v);
        chk(v[1] == 1'b1, "R6 zero write keeps", v, 2);
        reg_wr(A_FLAGS, 16'h0002);
        reg_rd(A_FLAGS, v);
        chk(v[1] == 1'b0, "R6 w1c clears", v, 0);
    endtask

    task automatic t_wide_write();
        int b = log_n;
        reg_wr(A_CFG, 16'h0100);
        reg_wr(A_CMD, 16'hAB70);
        reg_wr(A_WDATA, 16'hBEEF);
        wait_idle();
        chk(log_d[b] == 16'h0070, "R8 cmd upper byte zero", log_d[b], 16'h0070);
        chk(log_d[b+1] == 16'hBEEF, "R8 wide data", log_d[b+1], 16'hBEEF);
    endtask

    task automatic t_ready_irq();
        logic [15:0] v;
        nf_rb = 1'b0;
        repeat (5) @(negedge clk);
        nf_rb = 1'b1;
        repeat (5) @(negedge clk);
        reg_rd(A_FLAGS, v);
        chk(v[0] == 1'b1, "R7 ready edge", v, 1);
        chk(irq === 1'b0, "R11 masked irq", irq, 0);
        reg_wr(A_MASK, 16'h0001);
        #1 chk(irq === 1'b1, "R11 irq enabled", irq, 1);
        reg_wr(A_FLAGS, 16'h0001);
        #1 chk(irq === 1'b0, "R11 irq after clear", irq, 0);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        nf_rb = 1'b0;
        repeat (5) @(negedge clk);
        reg_wr(A_FLAGS, 16'h0007);
        @(negedge clk);
        nf_rb = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_addr = A_FLAGS; reg_wdata = 16'h0001;
        @(posedge clk); #1;
        reg_sel = 1'b0; reg_we = 1'b0;
        reg_rd(A_FLAGS, v);
        chk(v[0] == 1'b1, "R6 set wins over clear", v, 1);
        reg_wr(A_FLAGS, 16'h0001);
        reg_rd(A_FLAGS, v);
        chk(v[0] == 1'b0, "R6 lone clear", v, 0);
    endtask

    task automatic t_burst_rd();
        bit seen;
        int t0 = take_cnt;
        int b = log_n;
        reg_wr(A_CFG, 16'h0000);
        rdv_cnt = 0; rdv_bad = 0; rdv_base = flash_q;
        reg_wr(A_PAGE, 16'h0001);
        reg_wr(A_PAGE, 16'h0002);
        wait_flag(2, seen);
        wait_idle();
        chk(seen, "R9 page done", seen, 1);
        chk(rdv_cnt == 256, "R9 read burst length", rdv_cnt, 256);
        chk(rdv_bad == 0, "R9 read burst data", rdv_bad, 0);
        chk(log_n - b == 256, "R12 no extra cycles", log_n - b, 256);
        chk(take_cnt == t0, "R12 page write ignored", take_cnt, t0);
        reg_wr(A_FLAGS, 16'h0007);
    endtask

    task automatic t_burst_wr();
        bit seen;
        int bad = 0;
        int b = log_n;
        logic [15:0] v;
        reg_wr(A_PAGE, 16'h0003);
        repeat (4) @(negedge clk);
        chk(log_n == b && nf_ce_n === 1'b1, "R12 bad page value", log_n - b, 0);
        reg_wr(A_CFG, 16'h0300);
        reg_wr(A_PAGE, 16'h0002);
        wait_flag(2, seen);
        wait_idle();
        chk(seen, "R9 write page done", seen, 1);
        chk(take_cnt == 256, "R9 write burst takes", take_cnt, 256);
        chk(log_n - b == 256, "R9 write burst cycles", log_n - b, 256);
        for (int i = 0; i < 256; i++)
            if (log_kind[b+i] != 2 || log_d[b+i] != 16'h5000 + 16'(i)) bad++;
        chk(bad == 0, "R9 write burst data", bad, 0);
        reg_rd(A_FLAGS, v);
        chk(v[1] == 1'b0, "R9 burst leaves read ready clear", v, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_addr();
        t_full();
        t_read(1'b0);
        t_read(1'b1);
        t_wide_write();
        t_ready_irq();
        t_collide();
        t_burst_rd();
        t_burst_wr();
        summary();
        $finish;
    end

endmodule